// File: doc/BRIEF.md
# Status-Change Interrupt Controller

This block watches two status signals coming from the sensor side of the chip. The first is a single initialization-complete flag. The second is a two-bit vector that reports whether the I/O power rails are good. Both inputs pass through a two-flop synchronizer. The synchronized value can be read back from a read-only status word.

Whenever either source changes value, in either direction, the block latches a pending flag for that source. Each of the two power bits counts as part of one source. Software handles the pending flags through a small word-addressed register port:

- a write-1-to-clear state word;
- a read/write enable word;
- a write-only test word that forces flags on.

Each flag drives a level interrupt output while it is pending and enabled.

Top module: `stat_change_irq`

## Requirements
- R1: While reset is asserted and directly after it, the state word, the enable word, the status word and both interrupt outputs are zero.
- R2: A read at byte offset 0x50 returns the synchronized initialization flag in bit 0 and the power-good vector in bits 2:1, with all other bits zero. A change at the inputs that is sampled at clock edge k is visible after clock edge k+1.
- R3: Any change of either power-good bit, rising or falling, sets state bit 0 at the clock edge after the new value shows in the status word.
- R4: Any change of the initialization flag, rising or falling, sets state bit 1 at the clock edge after the new value shows in the status word.
- R5: The state word is at offset 0x00. Writing 1 to a bit clears that bit. Writing 0 leaves the bit unchanged. Without a write, a test write or a change event, the state word holds its value.
- R6: The enable word at offset 0x04 stores bits 1:0 as written, keeping the same bit meaning as the state word. Its other bits read as zero.
- R7: Writing 1 to a bit of the test word at offset 0x08 sets the matching state bit. The test word always reads as zero.
- R8: The I/O-change interrupt output is the AND of state bit 0 and enable bit 0. The init-change interrupt output is the AND of state bit 1 and enable bit 1. Each stays asserted until its state bit is cleared or its enable bit is cleared.
- R9: When a change event or a test write lands in the same cycle as a software clear of the same bit, the bit ends set.
- R10: The change detector starts from zero after reset. An input that is already high when reset is released therefore produces exactly one change flag.
- R11: Writes to the status word and to unmapped offsets have no effect, and reads from unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| initDoneAsync | input | 1 | Initialization-complete flag, asynchronous |
| powerGoodAsync | input | 2 | I/O power-good vector, asynchronous |
| regAddr | input | 7 | Byte address of the register access |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| irqIoChange | output | 1 | Level interrupt for a power-good change |
| irqInitChange | output | 1 | Level interrupt for an initialization change |

## Verification
The hardest case to reach from the ports is a software clear that lands in exactly the cycle a change event is detected. The detection happens three register stages after the input moves. To hit it, the bench toggles a power-good bit and then issues the clear after a delay that it sweeps over several values, so that one of those delays lines up with the detection edge. The startup case, where an input is high while reset is held, is covered by entering reset with the flag already high. On every clock the bench compares both interrupt pins and the word at the current read address with a behavioural model.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  // Number of change sources; index 0 is I/O power, index 1 is init.
  localparam int IrqCnt  = 2;
  localparam int IrqIo   = 0;
  localparam int IrqInit = 1;

  // Byte offsets of the register port
  localparam int OffState  = 'h00;
  localparam int OffEnable = 'h04;
  localparam int OffTest   = 'h08;
  localparam int OffStatus = 'h50;

  typedef enum logic [1:0] {
    RdNone,
    RdState,
    RdEnable,
    RdStatus
  } rdSel_e;

  // Strobes from control to datapath, one cycle per register write
  typedef struct packed {
    logic              wrState;
    logic              wrEnable;
    logic              wrTest;
    logic [IrqCnt-1:0] bits;
  } regStrobe_t;
endpackage

// File: rtl/stat_irq_sync.sv
module stat_irq_sync #(
  parameter int Width  = 3,
  parameter int Stages = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [Width-1:0] dIn,
  output logic [Width-1:0] dOut
);
  logic [Width-1:0] pipe [Stages];

  generate
    for (genvar s = 0; s < Stages; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pipe[s] <= '0;
          else       pipe[s] <= dIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pipe[s] <= '0;
          else       pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign dOut = pipe[Stages-1];
endmodule

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl
  import stat_irq_pkg::*;
#(
  parameter int AddrW = 7,
  parameter int DataW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AddrW-1:0] regAddr,
  input  logic             regWrEn,
  input  logic [DataW-1:0] regWrData,
  output regStrobe_t       strb,
  output rdSel_e           rdSel
);
  logic hitState, hitEnable, hitTest, hitStatus;
  logic unusedWrData;

  assign hitState  = (regAddr == AddrW'(OffState));
  assign hitEnable = (regAddr == AddrW'(OffEnable));
  assign hitTest   = (regAddr == AddrW'(OffTest));
  assign hitStatus = (regAddr == AddrW'(OffStatus));

  // Only the low bits carry meaning; the rest is dropped here.
  assign unusedWrData = ^regWrData[DataW-1:IrqCnt];

  always_comb begin
    strb          = '0;
    strb.wrState  = regWrEn && hitState;
    strb.wrEnable = regWrEn && hitEnable;
    strb.wrTest   = regWrEn && hitTest;
    strb.bits     = regWrData[IrqCnt-1:0];
  end

  always_comb begin
    rdSel = RdNone;
    if (hitState)       rdSel = RdState;
    else if (hitEnable) rdSel = RdEnable;
    else if (hitStatus) rdSel = RdStatus;
  end

  // R11
  ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && hitStatus) |-> !(strb.wrState || strb.wrEnable || strb.wrTest));
endmodule

// File: rtl/stat_irq_data.sv
module stat_irq_data
  import stat_irq_pkg::*;
#(
  parameter int PowerW     = 2,
  parameter int DataW      = 32,
  parameter int SyncStages = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initDoneAsync,
  input  logic [PowerW-1:0] powerGoodAsync,
  input  regStrobe_t        strb,
  input  rdSel_e            rdSel,
  output logic [DataW-1:0]  rdData,
  output logic              irqIo,
  output logic              irqInit
);
  localparam int StatW = PowerW + 1;

  logic [StatW-1:0]  statSync, statPrev;
  logic [IrqCnt-1:0] irqState, irqEnable, chgEvent;
  logic              ioChg, initChg;

  stat_irq_sync #(.Width(StatW), .Stages(SyncStages)) sync_i (
    .clk  (clk),
    .rstN (rstN),
    .dIn  ({powerGoodAsync, initDoneAsync}),
    .dOut (statSync)
  );

  // Previous value starts at zero so a high input at release counts as a change.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statPrev <= '0;
    else       statPrev <= statSync;
  end

  assign ioChg   = |(statSync[StatW-1:1] ^ statPrev[StatW-1:1]);
  assign initChg = statSync[0] ^ statPrev[0];

  always_comb begin
    chgEvent          = '0;
    chgEvent[IrqIo]   = ioChg;
    chgEvent[IrqInit] = initChg;
  end

  // Set sources override a clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqState <= '0;
    end else begin
      irqState <= (irqState & ~(strb.wrState ? strb.bits : '0))
                | chgEvent
                | (strb.wrTest ? strb.bits : '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              irqEnable <= '0;
    else if (strb.wrEnable) irqEnable <= strb.bits;
  end

  assign irqIo   = irqState[IrqIo]   & irqEnable[IrqIo];
  assign irqInit = irqState[IrqInit] & irqEnable[IrqInit];

  always_comb begin
    rdData = '0;
    case (rdSel)
      RdState:  rdData[IrqCnt-1:0] = irqState;
      RdEnable: rdData[IrqCnt-1:0] = irqEnable;
      RdStatus: rdData[StatW-1:0]  = statSync;
      default:  rdData = '0;
    endcase
  end

  // R3
  io_change_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    ioChg |=> irqState[IrqIo]);

  // R4
  init_change_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    initChg |=> irqState[IrqInit]);

  // R5
  state_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrState && !strb.wrTest && !ioChg && !initChg) |=> $stable(irqState));

  // R5
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrState && strb.bits[IrqInit] && !initChg) |=> !irqState[IrqInit]);

  // R6
  enable_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEnable |=> irqEnable == $past(strb.bits));

  // R7
  test_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrTest && strb.bits[IrqIo]) |=> irqState[IrqIo]);

  // R9
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrState && strb.bits[IrqIo] && ioChg) |=> irqState[IrqIo]);
endmodule

// File: rtl/stat_change_irq.sv
module stat_change_irq
  import stat_irq_pkg::*;
#(
  parameter int PowerW = 2,
  parameter int AddrW  = 7,
  parameter int DataW  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initDoneAsync,
  input  logic [PowerW-1:0] powerGoodAsync,
  input  logic [AddrW-1:0]  regAddr,
  input  logic              regWrEn,
  input  logic [DataW-1:0]  regWrData,
  output logic [DataW-1:0]  regRdData,
  output logic              irqIoChange,
  output logic              irqInitChange
);
  regStrobe_t strb;
  rdSel_e     rdSel;

  stat_irq_ctrl #(.AddrW(AddrW), .DataW(DataW)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .strb      (strb),
    .rdSel     (rdSel)
  );

  stat_irq_data #(.PowerW(PowerW), .DataW(DataW), .SyncStages(2)) data_i (
    .clk            (clk),
    .rstN           (rstN),
    .initDoneAsync  (initDoneAsync),
    .powerGoodAsync (powerGoodAsync),
    .strb           (strb),
    .rdSel          (rdSel),
    .rdData         (regRdData),
    .irqIo          (irqIoChange),
    .irqInit        (irqInitChange)
  );
endmodule

// File: tb/stat_change_irq_tb_top.sv
module stat_change_irq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic        initDone = 1'b1;
  logic [1:0]  pwrGood = 2'b00;
  logic [6:0]  regAddr = 7'h00;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  wire  [31:0] regRdData;
  wire         irqIoChange, irqInitChange;

  int    checks = 0;
  int    fails = 0;
  bit    started = 0;
  string phase = "R1";

  // Reference model state
  logic [1:0] mState = '0, mEn = '0;
  int         hist[$];
  int         mStat = 0, mPrev = 0;

  always #10 clk = ~clk;

  stat_change_irq dut_i (
    .clk(clk), .rstN(rstN), .initDoneAsync(initDone), .powerGoodAsync(pwrGood),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqIoChange(irqIoChange), .irqInitChange(irqInitChange)
  );

  // Behavioural model: input history queue, status is the sample two edges old.
  always @(posedge clk) begin
    if (!rstN) begin
      mState = '0; mEn = '0; mStat = 0; mPrev = 0;
      hist.delete();
    end else begin
      logic [1:0] setBits;
      setBits[0] = (mStat[2:1] != mPrev[2:1]);
      setBits[1] = (mStat[0] != mPrev[0]);
      if (regWrEn && regAddr == 7'h00) mState = mState & ~regWrData[1:0];
      mState = mState | setBits;
      if (regWrEn && regAddr == 7'h08) mState = mState | regWrData[1:0];
      if (regWrEn && regAddr == 7'h04) mEn = regWrData[1:0];
      hist.push_front({29'd0, pwrGood, initDone});
      mPrev = mStat;
      mStat = (hist.size() >= 2) ? hist[1] : 0;
      if (hist.size() > 4) void'(hist.pop_back());
    end
    started = 1;
  end

  function automatic logic [31:0] expRead(logic [6:0] a);
    case (a)
      7'h00:   return {30'd0, mState};
      7'h04:   return {30'd0, mEn};
      7'h50:   return mStat;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tagOf(logic [6:0] a);
    case (a)
      7'h00:   return "R5";
      7'h04:   return "R6";
      7'h08:   return "R7";
      7'h50:   return "R2";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (phase %s) at %0t: actual %h expected %h", req, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      check("R8", {30'd0, irqInitChange, irqIoChange}, {30'd0, mState & mEn});
      check(tagOf(regAddr), regRdData, expRead(regAddr));
    end
  end

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); #2;
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk); #2;
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdAt(logic [6:0] a);
    @(negedge clk); #2; regAddr = a;
  endtask

  task automatic setIn(logic i, logic [1:0] p);
    @(negedge clk); #2; initDone = i; pwrGood = p;
  endtask

  task automatic stimulus();
    #1 rstN = 1'b0;
    // R1: reset state, with the init flag already high
    phase = "R1";
    rdAt(7'h00); idle(1); rdAt(7'h04); idle(1); rdAt(7'h50); idle(1);
    rdAt(7'h00);
    @(negedge clk); #2; rstN = 1'b1;
    // R10: one init change after release
    phase = "R10";
    idle(6); rdAt(7'h50); idle(2); rdAt(7'h00); idle(2);
    // R5: write of zero keeps, write of one clears
    phase = "R5";
    wr(7'h00, 32'h0); idle(1); wr(7'h00, 32'h2); idle(2);
    // R6: enable word
    phase = "R6";
    wr(7'h04, 32'hFFFF_FFFF); rdAt(7'h04); idle(1); wr(7'h04, 32'h3);
    // R3: power changes in both directions, on each bit
    phase = "R3";
    setIn(1, 2'b01); idle(5); rdAt(7'h50); idle(1); wr(7'h00, 32'h1); idle(2);
    setIn(1, 2'b11); idle(5); wr(7'h00, 32'h1);
    setIn(1, 2'b00); idle(5); rdAt(7'h00); idle(1); wr(7'h00, 32'h1); idle(2);
    // R4: init falls, then rises
    phase = "R4";
    setIn(0, 2'b00); idle(5); wr(7'h00, 32'h2);
    setIn(1, 2'b00); idle(5); wr(7'h00, 32'h3); idle(2);
    // R7: test word sets flags and reads zero
    phase = "R7";
    wr(7'h08, 32'h1); rdAt(7'h08); idle(1); rdAt(7'h00); idle(1);
    wr(7'h08, 32'h2); idle(1); wr(7'h00, 32'h3); idle(1);
    // R9: sweep a clear across the change-detect edge
    phase = "R9";
    for (int d = 0; d < 6; d++) begin
      setIn(1, {1'b0, ~pwrGood[0]});
      idle(d);
      wr(7'h00, 32'h1);
      idle(6);
      wr(7'h00, 32'h3);
    end
    // R11: writes to status and unmapped offsets
    phase = "R11";
    wr(7'h50, 32'hFFFF_FFFF); rdAt(7'h50); idle(1);
    wr(7'h20, 32'hFFFF_FFFF); rdAt(7'h20); idle(1); rdAt(7'h00); idle(1);
    // R8: flag stays pending while enable drops
    phase = "R8";
    wr(7'h08, 32'h3); idle(2); wr(7'h04, 32'h1); idle(2);
    wr(7'h04, 32'h0); idle(2); wr(7'h04, 32'h2); idle(2);
    wr(7'h00, 32'h3); idle(3);
  endtask

  initial begin
    bit timedOut = 0;
    fork
      stimulus();
      begin repeat (20000) @(posedge clk); timedOut = 1; end
    join_any
    disable fork;
    if (timedOut) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule